// File: doc/BRIEF.md
# Block Floating Point Formatter

The formatter takes a buffered block of samples, each a signed two's-complement mantissa with a small signed exponent of its own, and rewrites the block so that every sample shares one exponent. For each sample it counts the redundant sign bits directly below the sign bit. The sample whose exponent minus that count is largest sets a reference exponent. A scaling offset, which gives headroom to a later filter, is added to the reference to form the shared block exponent. Every mantissa is then shifted by the block exponent minus its own exponent: to the right when this is positive, to the left when it is negative.

The whole block is presented in parallel on flat input buses and must stay stable while the formatter is busy. A start pulse begins a run. The first pass visits one sample per clock and accumulates the reference exponent. The second pass visits one sample per clock and writes its aligned mantissa into an output register. A one-cycle done pulse closes the run. In fixed-point mode all sample exponents are taken as zero, so the reference is the negated smallest sign-bit count of the block.

Top module: `bfp_formatter`

## Requirements
- R1: After reset, busy and done are 0, the block exponent is 0 and every aligned mantissa is 0.
- R2: The sign-bit count n of a mantissa is the number of bits below the sign bit, taken from the top, that equal the sign bit. A negative mantissa whose bits below that run are all zero uses n-1 instead, but never less than 0. An all-zero mantissa counts 11 (the full fraction width).
- R3: The block exponent is the maximum over the block of (e - n) plus the scaling offset S (S unsigned 0..7). It is a 6-bit two's-complement value.
- R4: Each aligned mantissa equals its input shifted by (block exponent - e). A positive amount is an arithmetic right shift that truncates toward minus infinity, and an amount of 12 or more leaves only sign bits. A negative amount is a left shift that is exact and never changes the sign.
- R5: While fxp_mode is 1 at start, the sample exponent bus is ignored and every exponent is taken as 0.
- R6: The edge that samples start is followed by 2N further edges, and done is then high for exactly one cycle. busy is high from the edge that samples start until done rises, and busy is low while done is high.
- R7: start is ignored while busy is high. Holding it high during a run neither restarts nor lengthens the run.
- R8: A start asserted in the cycle where done is high is accepted at once and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| fxp_mode | input | 1 | Treat all sample exponents as zero |
| scale | input | 3 | Scaling offset S, unsigned |
| in_mant | input | N*12 | Sample mantissas, sample l at bits [12l+11:12l] |
| in_exp | input | N*4 | Sample exponents (signed), sample l at bits [4l+3:4l] |
| out_mant | output | N*12 | Aligned mantissas, same packing as in_mant |
| out_exp | output | 6 | Block exponent, signed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The end of one run and the start of the next can fall in the same cycle. The bench raises start in the very cycle that done is seen. It then judges that busy rises at the next edge and that the second block's outputs, arriving 2N+1 edges later, match the model. A start held high across a whole run overlaps the counting passes, and the bench judges it by the unchanged run length. Expected exponents and mantissas come from an arithmetic model that finds the sign-bit count as the largest exact power-of-two scaling, so it does not repeat the bit-scan logic of the design.

// File: rtl/bfp_pkg.sv
// Package: shared types of the block floating point formatter.
// Assumes nothing beyond standard SystemVerilog.
package bfp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ALIGN = 2'd2
    } bfp_state_t;
endpackage

// File: rtl/bfp_sign_count.sv
// Module: counts the redundant sign bits of one mantissa.
// The count runs from the bit below the sign bit downward. A negative
// mantissa with only zeros below the run gets one less, floored at 0.
// An all-zero mantissa yields the full fraction width.
// Assumes MANT_W >= 2 and a CNT_W wide enough for MANT_W-1.
module bfp_sign_count #(
    parameter int MANT_W = 12,
    parameter int CNT_W  = 4
) (
    input  logic [MANT_W-1:0] mant,
    output logic [CNT_W-1:0]  cnt
);
    localparam int FRAC = MANT_W - 1;

    // Leading sign run length with the negative power-of-two correction
    always_comb begin : count_proc
        int   n;
        logic run;
        logic tail_zero;
        n         = 0;
        run       = 1'b1;
        tail_zero = 1'b1;
        for (int i = FRAC - 1; i >= 0; i--) begin
            if (run && (mant[i] == mant[FRAC])) n = n + 1;
            else                                run = 1'b0;
        end
        for (int i = 0; i < FRAC; i++) begin
            if ((i < FRAC - n) && mant[i]) tail_zero = 1'b0;
        end
        if (mant[FRAC] && tail_zero && (n > 0)) n = n - 1;
        cnt = CNT_W'(n);
    end
endmodule

// File: rtl/bfp_shifter.sv
// Module: bidirectional shifter of one mantissa.
// A positive amount shifts right arithmetically, and amounts of MANT_W or
// more leave only sign bits. A negative amount shifts left. The caller
// guarantees that a left shift stays within the redundant sign bits.
module bfp_shifter #(
    parameter int MANT_W = 12,
    parameter int SH_W   = 7
) (
    input  logic [MANT_W-1:0]     mant,
    input  logic signed [SH_W-1:0] amount,
    output logic [MANT_W-1:0]     result
);
    // Select direction and clamp long right shifts to sign fill
    always_comb begin : shift_proc
        int amt;
        amt = int'(amount);
        if (amt >= MANT_W)  result = {MANT_W{mant[MANT_W-1]}};
        else if (amt >= 0)  result = MANT_W'($signed(mant) >>> amt);
        else                result = mant << (-amt);
    end
endmodule

// File: rtl/bfp_ctrl.sv
// Module: sequencer of the two passes over the block.
// It accepts start only when idle, steps an index through N samples for
// the scan pass and again for the align pass, then pulses done.
// Assumes N >= 2.
module bfp_ctrl
    import bfp_pkg::*;
#(
    parameter int N     = 20,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             accept,
    output logic             scan,
    output logic             align,
    output logic             last,
    output logic [IDX_W-1:0] idx,
    output logic             busy,
    output logic             done
);
    bfp_state_t state_q;

    // Decode the state into pass strobes
    always_comb begin
        accept = (state_q == ST_IDLE) && start;
        scan   = (state_q == ST_SCAN);
        align  = (state_q == ST_ALIGN);
        last   = (idx == IDX_W'(N - 1));
        busy   = (state_q != ST_IDLE);
    end

    // Advance the state, the sample index and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SCAN;
                        idx     <= '0;
                    end
                end
                ST_SCAN: begin
                    if (last) begin
                        state_q <= ST_ALIGN;
                        idx     <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_ALIGN: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        idx     <= '0;
                        done    <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bfp_formatter.sv
// Module: block floating point formatter (top).
// Pass one finds max(e - n) over N samples. Pass two shifts every mantissa
// by (max + S - e). The input buses must stay stable while busy. The
// scaling offset and the mode are captured when start is accepted.
module bfp_formatter #(
    parameter int N       = 20,
    parameter int MANT_W  = 12,
    parameter int EXP_W   = 4,
    parameter int SCALE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  fxp_mode,
    input  logic [SCALE_W-1:0]    scale,
    input  logic [N*MANT_W-1:0]   in_mant,
    input  logic [N*EXP_W-1:0]    in_exp,
    output logic [N*MANT_W-1:0]   out_mant,
    output logic [5:0]            out_exp,
    output logic                  busy,
    output logic                  done
);
    localparam int FRAC    = MANT_W - 1;
    localparam int CNT_W   = $clog2(MANT_W);
    localparam int IDX_W   = $clog2(N);
    localparam int LOW_MAG = (1 << (EXP_W - 1)) + FRAC;
    localparam int HI_VAL  = (1 << (EXP_W - 1)) + (1 << SCALE_W) - 1;
    localparam int RANGE   = (LOW_MAG > HI_VAL) ? LOW_MAG : HI_VAL;
    localparam int BEXP_W  = $clog2(RANGE) + 1;
    localparam int SH_W    = BEXP_W + 1;

    logic              accept, scan, align, last;
    logic [IDX_W-1:0]  idx;
    logic [MANT_W-1:0] mant_arr [N];
    logic [EXP_W-1:0]  exp_arr  [N];
    logic [MANT_W-1:0] out_q    [N];
    logic [MANT_W-1:0] sel_mant;
    logic [EXP_W-1:0]  sel_exp;
    logic [CNT_W-1:0]  cnt;
    logic signed [BEXP_W-1:0] cand, acc_q, acc_max, bexp_q;
    logic signed [SH_W-1:0]   sh_amt;
    logic [MANT_W-1:0] shifted;
    logic [SCALE_W-1:0] scale_q;
    logic              fxp_q;

    bfp_ctrl #(.N(N), .IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .scan(scan), .align(align), .last(last), .idx(idx),
        .busy(busy), .done(done)
    );

    // Unpack the flat buses and pack the aligned results
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign mant_arr[g] = in_mant[g*MANT_W +: MANT_W];
        assign exp_arr[g]  = in_exp[g*EXP_W +: EXP_W];
        assign out_mant[g*MANT_W +: MANT_W] = out_q[g];
    end

    // Pick the visited sample; fixed-point mode zeroes its exponent
    always_comb begin
        sel_mant = mant_arr[idx];
        sel_exp  = fxp_q ? '0 : exp_arr[idx];
    end

    bfp_sign_count #(.MANT_W(MANT_W), .CNT_W(CNT_W)) count_i (
        .mant(sel_mant), .cnt(cnt)
    );

    // Candidate e - n, running maximum and shift amount
    always_comb begin
        cand    = $signed({{(BEXP_W-EXP_W){sel_exp[EXP_W-1]}}, sel_exp})
                - $signed({{(BEXP_W-CNT_W){1'b0}}, cnt});
        acc_max = (cand > acc_q) ? cand : acc_q;
        sh_amt  = $signed({bexp_q[BEXP_W-1], bexp_q})
                - $signed({{(SH_W-EXP_W){sel_exp[EXP_W-1]}}, sel_exp});
    end

    bfp_shifter #(.MANT_W(MANT_W), .SH_W(SH_W)) shift_i (
        .mant(sel_mant), .amount(sh_amt), .result(shifted)
    );

    // Capture settings, accumulate the reference, form the block exponent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            bexp_q  <= '0;
            scale_q <= '0;
            fxp_q   <= 1'b0;
        end else if (accept) begin
            acc_q   <= {1'b1, {(BEXP_W-1){1'b0}}};
            scale_q <= scale;
            fxp_q   <= fxp_mode;
        end else if (scan) begin
            acc_q <= acc_max;
            if (last) bexp_q <= acc_max + $signed({{(BEXP_W-SCALE_W){1'b0}}, scale_q});
        end
    end

    // Write each aligned mantissa during the second pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) out_q[i] <= '0;
        end else if (align) begin
            out_q[idx] <= shifted;
        end
    end

    assign out_exp = 6'($signed(bexp_q));
endmodule

// File: rtl/bfp_formatter_chk.sv
// Module: assertion checker for the formatter, bound to its top.
// It watches the control pulses, the running maximum and each written
// mantissa against its source sample.
module bfp_formatter_chk #(
    parameter int MANT_W = 12,
    parameter int BEXP_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     busy,
    input logic                     done,
    input logic                     scan,
    input logic                     align,
    input logic signed [BEXP_W-1:0] acc_q,
    input logic [MANT_W-1:0]        sel_mant,
    input logic [MANT_W-1:0]        shifted,
    input logic [5:0]               out_exp
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_EMAX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && $past(scan)) |-> (acc_q >= $past(acc_q))); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        align |-> ((shifted[MANT_W-1] == sel_mant[MANT_W-1]) || (shifted == '0))); // R4
    AST_EXP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (align && $past(align)) |-> $stable(out_exp)); // R3
endmodule

bind bfp_formatter bfp_formatter_chk #(.MANT_W(MANT_W), .BEXP_W(BEXP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .scan(scan),
    .align(align), .acc_q(acc_q), .sel_mant(sel_mant), .shifted(shifted),
    .out_exp(out_exp)
);

// File: tb/bfp_formatter_tb.sv
// Bench: sweeps scale, mode and magnitude classes against an arithmetic model.
module bfp_formatter_tb_top;
    localparam int N = 20;
    localparam int MW = 12;
    localparam int EW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fxp_mode = 1'b0;
    logic [2:0] scale = '0;
    logic [N*MW-1:0] in_mant = '0;
    logic [N*EW-1:0] in_exp = '0;
    logic [N*MW-1:0] out_mant;
    logic [5:0] out_exp;
    logic busy, done;

    int checks = 0;
    int errors = 0;
    int bm [N];
    int be [N];

    bfp_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fxp_mode(fxp_mode),
        .scale(scale), .in_mant(in_mant), .in_exp(in_exp),
        .out_mant(out_mant), .out_exp(out_exp), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    function automatic int model_count(input int m);
        int k;
        if (m == 0) return MW - 1;
        k = 0;
        for (int j = 0; j < MW; j++)
            if (m * (1 << j) <= 2047 && m * (1 << j) >= -2048) k = j;
        if (m < 0 && (((-m) & (-m - 1)) == 0) && k > 0) k--;
        return k;
    endfunction

    function automatic int model_shift(input int m, input int sh);
        int p;
        if (sh <= 0) return m * (1 << (-sh));
        p = 1 << sh;
        if (m >= 0) return m / p;
        return -((-m + p - 1) / p);
    endfunction

    task automatic load_block();
        for (int l = 0; l < N; l++) begin
            in_mant[l*MW +: MW] = MW'(bm[l]);
            in_exp[l*EW +: EW]  = EW'(be[l]);
        end
    endtask

    // Starts a run at the current negedge (may be the done cycle) and checks it
    task automatic run_block(input int s, input bit fx, input int hold, input string treq);
        int emax, bexp, cyc;
        load_block();
        scale = 3'(s);
        fxp_mode = fx;
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc >= hold) start = 1'b0;
            if (cyc == 1) check({treq, " busy after start"}, int'(busy), 1);
        end while (!done && cyc < 200);
        start = 1'b0;
        check({treq, " latency"}, cyc, 2 * N + 1);
        check("R6 busy low at done", int'(busy), 0);
        emax = -1000;
        for (int l = 0; l < N; l++) begin
            int e = fx ? 0 : be[l];
            if (e - model_count(bm[l]) > emax) emax = e - model_count(bm[l]);
        end
        bexp = emax + s;
        check(fx ? "R5 block exponent" : "R3 block exponent", int'($signed(out_exp)), bexp);
        for (int l = 0; l < N; l++) begin
            int e = fx ? 0 : be[l];
            check(fx ? "R5 aligned mantissa" : "R4 aligned mantissa",
                  int'($signed(out_mant[l*MW +: MW])), model_shift(bm[l], bexp - e));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 exponent", int'(out_exp), 0);
        check("R1 mantissas", int'(out_mant != '0), 0);

        // R2 directed: negative powers of two, -1, all-ones, zero
        for (int l = 0; l < N; l++) begin bm[l] = 0; be[l] = -8; end
        bm[0] = -512;  be[0] = 0;
        bm[1] = -2048; be[1] = -3;
        bm[2] = -1;    be[2] = -2;
        bm[3] = 1;     be[3] = -1;
        bm[4] = 2047;  be[4] = -6;
        @(negedge clk);
        run_block(0, 1'b0, 1, "R2");
        // R2 all-zero block: every count is the full width
        for (int l = 0; l < N; l++) begin bm[l] = 0; be[l] = l % 16 - 8; end
        @(negedge clk);
        run_block(3, 1'b0, 1, "R2");
        // R4 long right shifts: one large exponent, others small
        for (int l = 0; l < N; l++) begin bm[l] = (l % 2) ? -37 : 901; be[l] = -8; end
        bm[0] = 1024; be[0] = 7;
        @(negedge clk);
        run_block(7, 1'b0, 1, "R4");
        // R7: start held high across most of the run
        @(negedge clk);
        run_block(2, 1'b0, 2 * N, "R7");

        // Sweep scale, mode and magnitude class
        for (int s = 0; s < 8; s++)
            for (int fx = 0; fx < 2; fx++)
                for (int c = 0; c < 12; c++) begin
                    for (int l = 0; l < N; l++) begin
                        int r = int'($urandom_range(4095)) - 2048;
                        bm[l] = r >>> (($urandom_range(11) + c) % 12);
                        be[l] = int'($urandom_range(15)) - 8;
                    end
                    @(negedge clk);
                    run_block(s, fx[0], 1, "R6");
                end

        // R8: back-to-back start in the done cycle
        for (int l = 0; l < N; l++) begin bm[l] = 300 - 31 * l; be[l] = l % 5 - 2; end
        @(negedge clk);
        run_block(1, 1'b0, 1, "R6");
        for (int l = 0; l < N; l++) begin bm[l] = -7 * l; be[l] = 1 - l % 3; end
        run_block(4, 1'b0, 1, "R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule